// File: doc/BRIEF.md
# Ramp-Based Pixel Threshold Calibrator

This block trims the comparator threshold of every pixel in an array from one shared reference ramp. After a start request it raises a busy flag and drives a reference step code that begins at zero and climbs by one on every calibration tick, through all eight codes of a 3-bit range. Each pixel watches its own comparator. The first time that comparator reads high during the ramp, the pixel stores the code in force at that moment in its own calibration register. A pixel whose comparator stays low for the whole ramp is given the top code and marked out of range.

When the ramp ends, busy drops and the step code returns to zero. From then on the block drives each pixel's stored code as that pixel's offset select, which trims its threshold in normal operation. The offset selects are held at zero while a ramp is in progress, so every pixel is measured without any trim applied. A new start request clears all stored codes and flags before the next ramp begins.

Top module: `ramp_trim_calibrator`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), busy is 0, the step code is 0, every calibration code is 0, every out-of-range flag is 0 and every offset select is 0.
- R2: While busy, the step code advances by exactly one at each clock edge where cal_tick is high, and it holds when cal_tick is low. When busy is low, cal_tick has no effect.
- R3: A cal_start seen while idle raises busy at the next edge, with the step code at 0. A cal_tick in that same cycle is not counted. A cal_start seen while busy is ignored and does not restart the count.
- R4: Busy falls at the edge where cal_tick is high and the step code is 7 (the eighth step). The step code is then 0, and it stays 0 for as long as the block is idle.
- R5: At an edge where busy is high, a pixel whose comparator input is high and whose code has not yet been captured in this ramp stores the current step code. The code for pixel p sits in cal_codes bits [3p+2:3p].
- R6: Once a pixel has captured a code in a ramp, later comparator changes during that ramp leave its code and flag unchanged.
- R7: A pixel still uncaptured at the final edge of the ramp is loaded with code 7 and its out_of_range bit is set. A pixel whose comparator first goes high during step 7 stores 7 with its flag clear.
- R8: An accepted cal_start clears every calibration code and out-of-range flag at the same edge at which busy rises.
- R9: While idle, each pixel's offset select (trim_sel bits [3p+2:3p]) equals its stored code, and comparator inputs do not change any stored code. While busy, every offset select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Request to begin a calibration ramp |
| cal_tick | input | 1 | Calibration clock enable; advances one step |
| cmp_in | input | NPIX | Per-pixel comparator outputs |
| dac_code | output | CODE_W | Reference step code |
| busy | output | 1 | High while a ramp is in progress |
| cal_codes | output | NPIX*CODE_W | Stored calibration code for each pixel |
| out_of_range | output | NPIX | Pixel never fired during the last ramp |
| trim_sel | output | NPIX*CODE_W | Per-pixel offset select in normal mode |

## Verification
The bench targets the corner cases at the ends of the ramp. A pixel that is already high in the first busy cycle must store 0; a design that captured one cycle late would store 1. A pixel that fires only during step 7 must keep its flag clear, and a design that flagged every pixel holding code 7 would wrongly set it. A start request that arrives together with a tick, or in the middle of a ramp, must neither skip a step nor restart the ramp; an off-by-one or restart would show up as shifted codes. A pixel that toggles low and then high again after its capture must keep its first code, and comparator activity while idle must leave the stored codes and the offset selects untouched.

// File: rtl/ramp_cal_pkg.sv
// Package: shared types for the ramp calibrator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ramp_cal_pkg;
    typedef enum logic {
        CAL_IDLE = 1'b0,
        CAL_RAMP = 1'b1
    } cal_state_t;
endpackage

// File: rtl/ramp_stepper.sv
// Module: ramp_stepper
// Owns the ramp state and the step counter. It accepts a start only while
// idle and advances one step per tick. After the tick on the top code it
// returns to idle with the counter at zero.
// Assumes: cal_tick is a single-cycle enable that is synchronous to clk.
module ramp_stepper
    import ramp_cal_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              cal_tick,
    output logic              busy,
    output logic              accept,
    output logic              last_step,
    output logic [CODE_W-1:0] step
);
    localparam logic [CODE_W-1:0] STEP_MAX = {CODE_W{1'b1}};

    cal_state_t state;

    assign busy      = (state == CAL_RAMP);
    assign accept    = cal_start && !busy;
    assign last_step = busy && cal_tick && (step == STEP_MAX);

    // Purpose: ramp state and step counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAL_IDLE;
            step  <= '0;
        end else if (accept) begin
            state <= CAL_RAMP;
            step  <= '0;
        end else if (busy && cal_tick) begin
            if (step == STEP_MAX) begin
                state <= CAL_IDLE;
                step  <= '0;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    // R2: a tick below the top code advances the count by one
    a_r2_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_tick && step != STEP_MAX) |=> (step == $past(step) + 1'b1));
    // R3: a start during a ramp with no tick leaves the count unchanged
    a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_start && !cal_tick) |=> (busy && $stable(step)));
    // R4: the counter sits at zero whenever the block is idle
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (step == '0));
    // R4: busy falls right after the final tick
    a_r4_end: assert property (@(posedge clk) disable iff (!rst_n)
        last_step |=> !busy);
endmodule

// File: rtl/pix_cal_cell.sv
// Module: pix_cal_cell
// Calibration register for one pixel. During a ramp it captures the step
// code at the first high comparator sample. A pixel still uncaptured when
// the ramp ends gets the top code and an out-of-range mark.
// Assumes: cmp_in is already synchronised to clk.
module pix_cal_cell #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              busy,
    input  logic              last_step,
    input  logic [CODE_W-1:0] step,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] code,
    output logic              oor
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic captured;

    // Purpose: clear on start, capture the first flip, fill pixels that never fired.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code     <= '0;
            oor      <= 1'b0;
            captured <= 1'b0;
        end else if (busy && !captured) begin
            if (cmp_in) begin
                code     <= step;
                captured <= 1'b1;
            end else if (last_step) begin
                code     <= CODE_MAX;
                oor      <= 1'b1;
                captured <= 1'b1;
            end
        end
    end

    // R6: after capture, code and flag hold for the rest of the ramp
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && captured && !clear) |=> ($stable(code) && $stable(oor)));
    // R7: an out-of-range pixel always carries the top code
    a_r7_oor_max: assert property (@(posedge clk) disable iff (!rst_n)
        oor |-> (code == CODE_MAX));
    // R9: while idle, the comparator input cannot change the code
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clear) |=> $stable(code));
endmodule

// File: rtl/ramp_trim_calibrator.sv
// Module: ramp_trim_calibrator (top)
// One shared reference ramp fills a calibration register in every pixel.
// In normal mode the stored codes drive the per-pixel offset selects.
// Assumes: every input is synchronous to clk; the analog DAC lies outside.
module ramp_trim_calibrator #(
    parameter int NPIX   = 8,
    parameter int CODE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cal_start,
    input  logic                     cal_tick,
    input  logic [NPIX-1:0]          cmp_in,
    output logic [CODE_W-1:0]        dac_code,
    output logic                     busy,
    output logic [NPIX*CODE_W-1:0]   cal_codes,
    output logic [NPIX-1:0]          out_of_range,
    output logic [NPIX*CODE_W-1:0]   trim_sel
);
    localparam int BUS_W = NPIX * CODE_W;

    logic              accept;
    logic              last_step;
    logic [CODE_W-1:0] step;

    ramp_stepper #(.CODE_W(CODE_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_start (cal_start),
        .cal_tick  (cal_tick),
        .busy      (busy),
        .accept    (accept),
        .last_step (last_step),
        .step      (step)
    );

    assign dac_code = step;

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        pix_cal_cell #(.CODE_W(CODE_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (accept),
            .busy      (busy),
            .last_step (last_step),
            .step      (step),
            .cmp_in    (cmp_in[p]),
            .code      (cal_codes[p*CODE_W +: CODE_W]),
            .oor       (out_of_range[p])
        );
    end

    // Purpose: offset selects follow the stored codes only outside a ramp.
    always_comb begin
        trim_sel = busy ? '0 : cal_codes;
    end

    // R8: an accepted start leaves every code and flag cleared
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cal_codes == '0 && out_of_range == '0));
    // R9: no trim is applied while a ramp is running
    a_r9_trim_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (trim_sel == {BUS_W{1'b0}}));
    // R3: busy rises right after an accepted start
    a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
endmodule

// File: tb/sim_ramp_trim_calibrator.sv
module sim_ramp_trim_calibrator;
    localparam int NP = 8;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_start = 1'b0;
    logic cal_tick = 1'b0;
    logic [NP-1:0] cmp_in = '0;
    logic [CW-1:0] dac_code;
    logic busy;
    logic [NP*CW-1:0] cal_codes;
    logic [NP-1:0] out_of_range;
    logic [NP*CW-1:0] trim_sel;

    always #4 clk = ~clk;   // 125 MHz

    ramp_trim_calibrator #(.NPIX(NP), .CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_tick(cal_tick),
        .cmp_in(cmp_in), .dac_code(dac_code), .busy(busy), .cal_codes(cal_codes),
        .out_of_range(out_of_range), .trim_sel(trim_sel)
    );

    int n_checks = 0;
    int n_fail = 0;

    // behavioural reference state
    int m_busy = 0;
    int m_step = 0;
    int m_code[NP];
    int m_capt[NP];
    int m_oor[NP];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [NP*CW-1:0] ec;
        logic [NP-1:0] eo;
        ec = '0; eo = '0;
        for (int p = 0; p < NP; p++) begin
            ec[p*CW +: CW] = CW'(m_code[p]);
            eo[p] = (m_oor[p] != 0);
        end
        check("R2/R4 dac_code", 64'(dac_code), 64'(m_step));
        check("R3 busy", 64'(busy), 64'(m_busy));
        check("R5/R6/R7 cal_codes", 64'(cal_codes), 64'(ec));
        check("R7/R8 out_of_range", 64'(out_of_range), 64'(eo));
        check("R9 trim_sel", 64'(trim_sel), (m_busy != 0) ? 64'd0 : 64'(ec));
    endtask

    task automatic model_reset();
        m_busy = 0; m_step = 0;
        for (int p = 0; p < NP; p++) begin
            m_code[p] = 0; m_capt[p] = 0; m_oor[p] = 0;
        end
    endtask

    // one clock: drive at the falling edge, advance the model, compare at the next falling edge
    task automatic cyc(input logic s, input logic t, input logic [NP-1:0] c);
        int last;
        cal_start = s; cal_tick = t; cmp_in = c;
        last = (m_busy != 0 && t && m_step == 7) ? 1 : 0;
        for (int p = 0; p < NP; p++) begin
            if (m_busy == 0 && s) begin
                m_code[p] = 0; m_capt[p] = 0; m_oor[p] = 0;
            end else if (m_busy != 0 && m_capt[p] == 0) begin
                if (c[p]) begin
                    m_code[p] = m_step; m_capt[p] = 1;
                end else if (last != 0) begin
                    m_code[p] = 7; m_oor[p] = 1; m_capt[p] = 1;
                end
            end
        end
        if (m_busy == 0 && s) begin
            m_busy = 1; m_step = 0;
        end else if (m_busy != 0 && t) begin
            if (m_step == 7) begin m_busy = 0; m_step = 0; end
            else m_step++;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [NP-1:0] pattern_a(input int st);
        logic [NP-1:0] v;
        for (int p = 0; p < NP - 1; p++) v[p] = (st >= p);
        v[2] = (st == 2) || (st >= 5);   // R6: toggles after its capture
        v[NP-1] = 1'b0;                  // R7: never fires
        return v;
    endfunction

    initial begin
        repeat (400000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();                                    // R1 reset state

        // R2/R9: ticks and comparator activity while idle change nothing
        for (int i = 0; i < 6; i++) cyc(1'b0, i[0], NP'(8'hA5 ^ i));

        // ramp 1: ticks every other cycle, starts issued mid-ramp (R3)
        cyc(1'b1, 1'b0, '1);                              // R3 accept; comparators ignored while idle
        for (int i = 0; i < 40 && m_busy != 0; i++) begin
            cyc((i == 3) || (i == 8), i[0], pattern_a(m_step));
        end
        check("R4 busy low after ramp 1", 64'(busy), 64'd0);
        check("R5 pixel 0 stored 0", 64'(cal_codes[0 +: CW]), 64'd0);
        check("R6 pixel 2 kept first code", 64'(cal_codes[2*CW +: CW]), 64'd2);
        check("R7 pixel 7 out of range", 64'(out_of_range[NP-1]), 64'd1);
        check("R7 pixel 6 code 6", 64'(cal_codes[6*CW +: CW]), 64'd6);
        check("R9 trim of pixel 5", 64'(trim_sel[5*CW +: CW]), 64'd5);

        // idle with comparator toggling: stored codes must hold (R9)
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, NP'(8'h3C << i));

        // ramp 2: start together with a tick (tick not counted), all pixels high at once
        cyc(1'b1, 1'b1, '0);
        check("R8 codes cleared on start", 64'(cal_codes), 64'd0);
        check("R8 flags cleared on start", 64'(out_of_range), 64'd0);
        check("R3 step 0 after start with tick", 64'(dac_code), 64'd0);
        cyc(1'b0, 1'b0, '1);                              // R5 all capture 0
        for (int i = 0; i < 20 && m_busy != 0; i++) cyc(1'b0, 1'b1, NP'(i));
        check("R5 all pixels code 0", 64'(cal_codes), 64'd0);

        // ramp 3: only pixel 3 fires, during step 7
        cyc(1'b1, 1'b0, '0);
        for (int i = 0; i < 20 && m_busy != 0; i++) begin
            cyc(1'b0, 1'b1, (m_step == 7) ? NP'(8'h08) : '0);
        end
        check("R7 pixel 3 code 7", 64'(cal_codes[3*CW +: CW]), 64'd7);
        check("R7 pixel 3 flag clear", 64'(out_of_range[3]), 64'd0);
        check("R7 other pixels flagged", 64'(out_of_range), 64'(8'hF7));

        // reset mid-ramp
        cyc(1'b1, 1'b1, '0);
        cyc(1'b0, 1'b1, '0);
        rst_n = 1'b0;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();                                    // R1 after reset
        cyc(1'b0, 1'b1, '1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule